// File: doc/BRIEF.md
# Multi-Mode Reloadable Down-Counter Timer

This block is a 16-bit down-counter with a reload latch, used as a general-purpose timer inside a larger chip. A 3-bit mode input selects its behaviour. In timer mode it counts down on a count-source tick. In pulse mode it does the same and also flips an output on every underflow. In event mode it counts edges of an external input. In width mode it measures how long that input stays at a chosen level. On every underflow the counter reloads from the latch and raises a sticky interrupt flag.

The count source is either a prescaled base tick or a separate slow tick. The prescaler divides the base tick by 16, 1, 2 or 256. Software writes a new period one byte at a time: first the low byte, which is held in a staging register, then the high byte, which commits the whole word. A write-control input chooses between two write styles. One loads the latch and the counter at once. The other loads the latch only, so the running period finishes first and the new value is used from the next underflow onward. One 2-bit edge code sets, all together, the counting edge in event mode, the measured level in width mode and the edge that ends a measurement.

Top module: `reload_timer`

## Requirements
- R1: With `writeCtl`=0, a high-byte write loads both the latch and the counter with {high byte, staged low byte} in the next cycle. A low-byte write alone changes neither the latch nor the counter.
- R2: With `writeCtl`=1, a high-byte write updates the latch only and leaves the counter running. The new value first reaches the counter at the following underflow.
- R3: In timer mode (`mode`=000), each enabled source tick decrements the counter. A tick that arrives while the counter is 0 reloads it from the latch and sets `irqFlag`. The period is therefore latch+1 ticks.
- R4: With `srcSel`=0, the count source is the prescaled `baseTick`. `divSel` 00, 01, 10 and 11 give one count every 16, 1, 2 and 256 base ticks.
- R5: With `srcSel`=1, the count source is `subTick`, and `baseTick` has no effect on the counter.
- R6: While `countStop`=1, the counter holds its value in timer, pulse and event modes.
- R7: In event mode (`mode`=100), the counter decrements on the rising edges of `evtIn` for `edgeSel`=00, on the falling edges for 01, and on both edges for 10 or 11.
- R8: In event mode, `windowOff`=1 blocks event counting.
- R9: While `mode` is not 001, `pulseOut` follows `outInit`. In pulse mode (`mode`=001), `pulseOut` starts from that level and inverts on every underflow.
- R10: In width mode (`mode`=101), the counter decrements on source ticks while `evtIn` is high (`edgeSel`=00) or low (`edgeSel`=01). The edge that ends the level copies the count to `measured`, reloads the counter from the latch and sets `irqFlag`. With `edgeSel[1]`=1 nothing is measured.
- R11: `irqFlag` stays set until `irqClr` is pulsed. A set event in the same cycle as `irqClr` wins.
- R12: The mode codes 010, 011, 110 and 111 freeze the counter and raise no interrupt.
- R13: When an underflow falls in the same cycle as a direct load, the loaded value wins for the counter and `irqFlag` is still set. When an underflow falls in the same cycle as a latch-only commit, the counter reloads from the previous latch value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseTick | input | 1 | Base count-source enable pulse, before the prescaler |
| subTick | input | 1 | Secondary slow count-source enable pulse |
| srcSel | input | 1 | 0 selects the prescaler output, 1 selects subTick |
| divSel | input | 2 | Prescaler code: 00 /16, 01 /1, 10 /2, 11 /256 |
| mode | input | 3 | Operating mode code |
| countStop | input | 1 | 1 halts counting |
| windowOff | input | 1 | 1 blocks event counting |
| edgeSel | input | 2 | Edge or level code for event and width modes |
| evtIn | input | 1 | External event input, already synchronous |
| outInit | input | 1 | Starting level of pulseOut |
| writeCtl | input | 1 | 0 loads latch and counter, 1 loads the latch only |
| wrLo | input | 1 | Low-byte write strobe (staged) |
| wrHi | input | 1 | High-byte write strobe (commits the word) |
| wrData | input | 8 | Write data byte |
| irqClr | input | 1 | Pulse 1 to clear irqFlag |
| count | output | 16 | Current counter value |
| latchVal | output | 16 | Current reload latch value |
| measured | output | 16 | Count captured at the end of a width measurement |
| irqFlag | output | 1 | Sticky interrupt flag |
| pulseOut | output | 1 | Pulse-mode output |

## Verification
Two functions can meet in the same cycle: an underflow, and a high-byte write that loads the counter or commits the latch. The bench provokes this by parking the counter at zero with a known latch. It then raises the source tick in the same cycle as the high-byte strobe, once in each write style. It judges the result from the next counter and latch values and from `irqFlag`. The same method is used with the tick coinciding with `irqClr`, to show that setting the flag takes priority over clearing it.

// File: rtl/reload_timer_pkg.sv
package reload_timer_pkg;

  typedef enum logic [2:0] {
    MODE_TIMER  = 3'b000,
    MODE_PULSE  = 3'b001,
    MODE_BRIDGE = 3'b010,
    MODE_PWM    = 3'b011,
    MODE_EVENT  = 3'b100,
    MODE_WIDTH  = 3'b101
  } tmrModeE;

  typedef enum logic [1:0] {
    DIV_16  = 2'b00,
    DIV_1   = 2'b01,
    DIV_2   = 2'b10,
    DIV_256 = 2'b11
  } divCodeE;

  // strobes passed from control to datapath each cycle
  typedef struct packed {
    logic countEn;    // decrement (or reload at zero) this cycle
    logic measEnd;    // terminating edge of a width measurement
    logic stageLo;    // capture low byte into staging
    logic commitHi;   // commit {hi, staged lo} into the latch
    logic loadCnt;    // also load the counter with the written word
    logic irqClr;     // clear request for the flag
    logic pulseMode;  // pulse output mode active
  } strobeT;

endpackage

// File: rtl/reload_timer_ctrl.sv
module reload_timer_ctrl
  import reload_timer_pkg::*;
#(
  parameter int PRE_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baseTick,
  input  logic       subTick,
  input  logic       srcSel,
  input  logic [1:0] divSel,
  input  logic [2:0] mode,
  input  logic       countStop,
  input  logic       windowOff,
  input  logic [1:0] edgeSel,
  input  logic       evtIn,
  input  logic       writeCtl,
  input  logic       wrLo,
  input  logic       wrHi,
  input  logic       irqClr,
  output strobeT     strb
);

  localparam int DIV16_W = 4;

  logic [PRE_W-1:0] preQ;
  logic             preTick;
  logic             srcTick;
  logic             evtQ;
  logic             riseEdge;
  logic             fallEdge;
  logic             evtTick;
  logic             measLevel;
  logic             termEdge;
  tmrModeE          curMode;

  // free-running prescaler advanced by the base tick
  always_ff @(posedge clk) begin
    if (!rstN)         preQ <= '0;
    else if (baseTick) preQ <= preQ + 1'b1;
  end

  always_comb begin
    case (divCodeE'(divSel))
      DIV_1:   preTick = baseTick;
      DIV_2:   preTick = baseTick & preQ[0];
      DIV_16:  preTick = baseTick & (&preQ[DIV16_W-1:0]);
      default: preTick = baseTick & (&preQ);
    endcase
  end

  assign srcTick = srcSel ? subTick : preTick;

  // edge detection on the external input
  always_ff @(posedge clk) begin
    if (!rstN) evtQ <= 1'b0;
    else       evtQ <= evtIn;
  end

  assign riseEdge = evtIn & ~evtQ;
  assign fallEdge = ~evtIn & evtQ;

  always_comb begin
    case (edgeSel)
      2'b00:   evtTick = riseEdge;
      2'b01:   evtTick = fallEdge;
      default: evtTick = riseEdge | fallEdge;
    endcase
  end

  // width mode: code 00 measures high, 01 measures low
  assign measLevel = edgeSel[0] ? ~evtIn : evtIn;
  assign termEdge  = edgeSel[0] ? riseEdge : fallEdge;

  assign curMode = tmrModeE'(mode);

  always_comb begin
    strb = '0;
    case (curMode)
      MODE_TIMER, MODE_PULSE:
        strb.countEn = srcTick & ~countStop;
      MODE_EVENT:
        strb.countEn = evtTick & ~windowOff & ~countStop;
      MODE_WIDTH: begin
        strb.countEn = srcTick & ~countStop & measLevel & ~edgeSel[1];
        strb.measEnd = termEdge & ~edgeSel[1];
      end
      default: strb.countEn = 1'b0;
    endcase
    strb.stageLo   = wrLo;
    strb.commitHi  = wrHi;
    strb.loadCnt   = wrHi & ~writeCtl;
    strb.irqClr    = irqClr;
    strb.pulseMode = (curMode == MODE_PULSE);
  end

endmodule

// File: rtl/reload_timer_dp.sv
module reload_timer_dp
  import reload_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobeT          strb,
  input  logic [W/2-1:0]  wrData,
  input  logic            outInit,
  output logic [W-1:0]    count,
  output logic [W-1:0]    latchVal,
  output logic [W-1:0]    measured,
  output logic            irqFlag,
  output logic            pulseOut
);

  localparam int BW = W / 2;

  logic [BW-1:0] stageQ;
  logic [W-1:0]  latchQ;
  logic [W-1:0]  cntQ;
  logic [W-1:0]  capQ;
  logic [W-1:0]  wordIn;
  logic          irqQ;
  logic          pulseQ;
  logic          underflow;

  assign wordIn    = {wrData, stageQ};
  assign underflow = strb.countEn & (cntQ == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageQ <= '0;
      latchQ <= '0;
    end else begin
      if (strb.stageLo)  stageQ <= wrData;
      if (strb.commitHi) latchQ <= wordIn;
    end
  end

  // counter: direct load wins, then measurement end, then counting
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
      capQ <= '0;
    end else if (strb.loadCnt) begin
      cntQ <= wordIn;
    end else if (strb.measEnd) begin
      capQ <= cntQ;
      cntQ <= latchQ;
    end else if (strb.countEn) begin
      cntQ <= underflow ? latchQ : cntQ - 1'b1;
    end
  end

  // sticky flag, set has priority over clear
  always_ff @(posedge clk) begin
    if (!rstN)                         irqQ <= 1'b0;
    else if (underflow | strb.measEnd) irqQ <= 1'b1;
    else if (strb.irqClr)              irqQ <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               pulseQ <= 1'b0;
    else if (!strb.pulseMode) pulseQ <= outInit;
    else if (underflow)       pulseQ <= ~pulseQ;
  end

  assign count    = cntQ;
  assign latchVal = latchQ;
  assign measured = capQ;
  assign irqFlag  = irqQ;
  assign pulseOut = pulseQ;

endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import reload_timer_pkg::*;
#(
  parameter int W     = 16,
  parameter int PRE_W = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           baseTick,
  input  logic           subTick,
  input  logic           srcSel,
  input  logic [1:0]     divSel,
  input  logic [2:0]     mode,
  input  logic           countStop,
  input  logic           windowOff,
  input  logic [1:0]     edgeSel,
  input  logic           evtIn,
  input  logic           outInit,
  input  logic           writeCtl,
  input  logic           wrLo,
  input  logic           wrHi,
  input  logic [W/2-1:0] wrData,
  input  logic           irqClr,
  output logic [W-1:0]   count,
  output logic [W-1:0]   latchVal,
  output logic [W-1:0]   measured,
  output logic           irqFlag,
  output logic           pulseOut
);

  strobeT strb;

  reload_timer_ctrl #(.PRE_W(PRE_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .baseTick  (baseTick),
    .subTick   (subTick),
    .srcSel    (srcSel),
    .divSel    (divSel),
    .mode      (mode),
    .countStop (countStop),
    .windowOff (windowOff),
    .edgeSel   (edgeSel),
    .evtIn     (evtIn),
    .writeCtl  (writeCtl),
    .wrLo      (wrLo),
    .wrHi      (wrHi),
    .irqClr    (irqClr),
    .strb      (strb)
  );

  reload_timer_dp #(.W(W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (wrData),
    .outInit  (outInit),
    .count    (count),
    .latchVal (latchVal),
    .measured (measured),
    .irqFlag  (irqFlag),
    .pulseOut (pulseOut)
  );

endmodule

// File: rtl/reload_timer_chk.sv
module reload_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic [2:0]   mode,
  input logic         countStop,
  input logic         srcSel,
  input logic         subTick,
  input logic         wrHi,
  input logic         writeCtl,
  input logic         irqClr,
  input logic         outInit,
  input logic [W-1:0] count,
  input logic [W-1:0] latchVal,
  input logic         irqFlag,
  input logic         pulseOut
);

  a_r1_direct_load: assert property (@(posedge clk) disable iff (!rstN)
    (wrHi && !writeCtl) |=> (count == latchVal));

  a_r2_latch_only: assert property (@(posedge clk) disable iff (!rstN)
    (wrHi && writeCtl && count != '0) |=>
      (count == $past(count) || count == $past(count) - 1'b1));

  a_r3_decrement: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'b000 && !countStop && srcSel && subTick && !wrHi && count != '0)
      |=> (count == $past(count) - 1'b1));

  a_r6_stop_holds: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'b000 && countStop && !wrHi) |=> $stable(count));

  a_r9_idle_level: assert property (@(posedge clk) disable iff (!rstN)
    (mode != 3'b001) |=> (pulseOut == $past(outInit)));

  a_r11_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !irqClr) |=> irqFlag);

  a_r12_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (mode[1] && !wrHi) |=> $stable(count));

endmodule

bind reload_timer reload_timer_chk #(.W(W)) u_chk (.*);

// File: tb/test_reload_timer.sv
module test_reload_timer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        baseTick = 0, subTick = 0, srcSel = 0;
  logic [1:0]  divSel = 0;
  logic [2:0]  mode = 0;
  logic        countStop = 0, windowOff = 0;
  logic [1:0]  edgeSel = 0;
  logic        evtIn = 0, outInit = 0, writeCtl = 0;
  logic        wrLo = 0, wrHi = 0;
  logic [7:0]  wrData = 0;
  logic        irqClr = 0;
  logic [15:0] count, latchVal, measured;
  logic        irqFlag, pulseOut;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  reload_timer i_reload_timer (
    .clk(clk), .rstN(rstN), .baseTick(baseTick), .subTick(subTick),
    .srcSel(srcSel), .divSel(divSel), .mode(mode), .countStop(countStop),
    .windowOff(windowOff), .edgeSel(edgeSel), .evtIn(evtIn),
    .outInit(outInit), .writeCtl(writeCtl), .wrLo(wrLo), .wrHi(wrHi),
    .wrData(wrData), .irqClr(irqClr), .count(count), .latchVal(latchVal),
    .measured(measured), .irqFlag(irqFlag), .pulseOut(pulseOut)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  endtask

  task automatic writeVal(input logic [15:0] v, input logic ctl);
    writeCtl = ctl;
    wrLo = 1; wrData = v[7:0]; cyc();
    wrLo = 0; wrHi = 1; wrData = v[15:8]; cyc();
    wrHi = 0;
  endtask

  task automatic clearIrq();
    irqClr = 1; cyc(); irqClr = 0;
  endtask

  task automatic evtPulses(input int n);
    for (int i = 0; i < n; i++) begin
      evtIn = 1; cyc();
      evtIn = 0; cyc();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) cyc();
    rstN = 1;
    cyc();
    chk("reset count", count, 0);
    chk("reset latch", latchVal, 0);
    chk("reset irq", irqFlag, 0);

    // R1: staged low byte, direct load
    wrLo = 1; wrData = 8'h34; cyc(); wrLo = 0; cyc();
    chk("R1 low byte alone latch", latchVal, 0);
    chk("R1 low byte alone count", count, 0);
    writeVal(16'h1234, 0);
    chk("R1 direct count", count, 16'h1234);
    chk("R1 direct latch", latchVal, 16'h1234);

    // R3: period sweep in timer mode
    srcSel = 1;
    for (int l = 0; l <= 6; l++) begin
      writeVal(16'(l), 0);
      clearIrq();
      subTick = 1;
      for (int k = 1; k <= 2 * l + 3; k++) begin
        cyc();
        chk("R3 count", count, l - (k % (l + 1)));
        chk("R3 irq", irqFlag, (k >= l + 1) ? 1 : 0);
      end
      subTick = 0;
    end

    // R4: prescaler ratios
    srcSel = 0;
    for (int d = 0; d < 4; d++) begin
      int n;
      int expDiv;
      logic [15:0] prev;
      baseTick = 0;
      writeVal(16'h0FFF, 0);
      divSel = 2'(d);
      baseTick = 1;
      expDiv = (d == 0) ? 16 : (d == 1) ? 1 : (d == 2) ? 2 : 256;
      prev = count; n = 0;
      while (count == prev && n < 600) begin cyc(); n++; end
      prev = count; n = 0;
      do begin cyc(); n++; end while (count == prev && n < 600);
      chk("R4 divide ratio", n, expDiv);
      chk("R4 step size", prev - count, 1);
    end
    baseTick = 0;

    // R5: secondary source ignores base tick
    srcSel = 1; divSel = 2'b01;
    writeVal(16'd200, 0);
    baseTick = 1;
    repeat (20) cyc();
    chk("R5 base ignored", count, 200);
    subTick = 1; repeat (3) cyc(); subTick = 0;
    chk("R5 sub ticks", count, 197);
    baseTick = 0;

    // R6: stop
    countStop = 1; subTick = 1;
    repeat (10) cyc();
    chk("R6 stopped", count, 197);
    subTick = 0; countStop = 0;

    // R7: event edges
    mode = 3'b100;
    for (int e = 0; e < 4; e++) begin
      edgeSel = 2'(e);
      writeVal(16'd100, 0);
      evtPulses(4);
      chk("R7 event edges", count, (e < 2) ? 96 : 92);
    end

    // R8: window off
    windowOff = 1; edgeSel = 2'b10;
    writeVal(16'd100, 0);
    evtPulses(4);
    chk("R8 window blocks", count, 100);
    windowOff = 0;

    // R9: pulse output
    for (int o = 0; o < 2; o++) begin
      mode = 3'b000; subTick = 0;
      writeVal(16'd2, 0);
      outInit = 1'(o); cyc();
      chk("R9 idle follows init", pulseOut, o);
      mode = 3'b001; cyc();
      chk("R9 start level", pulseOut, o);
      subTick = 1;
      for (int k = 1; k <= 9; k++) begin
        cyc();
        chk("R9 toggle", pulseOut, o ^ ((k / 3) % 2));
      end
      subTick = 0;
    end
    mode = 3'b000;

    // R10: width measurement, high pulses
    mode = 3'b101; edgeSel = 2'b00; evtIn = 0; subTick = 0;
    writeVal(16'd1000, 0);
    clearIrq();
    for (int h = 1; h <= 5; h++) begin
      subTick = 1; evtIn = 1;
      repeat (h) cyc();
      evtIn = 0; cyc();
      chk("R10 high width", measured, 1000 - h);
      chk("R10 reload", count, 1000);
      chk("R10 irq", irqFlag, 1);
      subTick = 0;
      clearIrq();
    end
    // low pulses
    edgeSel = 2'b01; evtIn = 1; cyc();
    clearIrq();
    for (int w = 1; w <= 3; w++) begin
      subTick = 1; evtIn = 0;
      repeat (w) cyc();
      evtIn = 1; cyc();
      chk("R10 low width", measured, 1000 - w);
      chk("R10 low reload", count, 1000);
      subTick = 0;
      clearIrq();
    end
    // top edge bit set: no measurement
    edgeSel = 2'b10; subTick = 1;
    evtIn = 0; cyc(); evtIn = 1; cyc(); evtIn = 0; cyc();
    chk("R10 disabled count", count, 1000);
    chk("R10 disabled irq", irqFlag, 0);
    subTick = 0; evtIn = 0; edgeSel = 2'b00;
    mode = 3'b000;

    // R2: latch-only write
    writeVal(16'd50, 0);
    subTick = 1; repeat (10) cyc(); subTick = 0;
    writeVal(16'd7, 1);
    chk("R2 count kept", count, 40);
    chk("R2 latch new", latchVal, 7);
    wrLo = 1; wrData = 8'h99; cyc(); wrLo = 0;
    chk("R2 low byte no commit", latchVal, 7);
    subTick = 1; repeat (41) cyc(); subTick = 0;
    chk("R2 new period at underflow", count, 7);

    // R11: set wins over clear, latch-only reload
    writeVal(16'd0, 0);
    writeVal(16'd5, 1);
    subTick = 1; irqClr = 1; cyc(); subTick = 0; irqClr = 0;
    chk("R11 set beats clear", irqFlag, 1);
    chk("R11 reload from latch", count, 5);
    repeat (5) cyc();
    chk("R11 sticky", irqFlag, 1);
    clearIrq();
    chk("R11 cleared", irqFlag, 0);

    // R13: direct load coincident with underflow
    writeVal(16'd0, 0);
    clearIrq();
    wrLo = 1; wrData = 8'h23; cyc(); wrLo = 0;
    writeCtl = 0; wrHi = 1; wrData = 8'h01; subTick = 1; cyc();
    wrHi = 0; subTick = 0;
    chk("R13 load wins", count, 16'h0123);
    chk("R13 irq still set", irqFlag, 1);
    // latch-only commit coincident with underflow
    writeVal(16'd0, 0);
    writeVal(16'd5, 1);
    wrLo = 1; wrData = 8'h09; cyc(); wrLo = 0;
    writeCtl = 1; wrHi = 1; wrData = 8'h00; subTick = 1; cyc();
    wrHi = 0; subTick = 0;
    chk("R13 old latch reloaded", count, 5);
    chk("R13 latch committed", latchVal, 9);

    // R12: reserved and out-of-scope modes freeze
    for (int m = 0; m < 4; m++) begin
      logic [2:0] code;
      code = (m == 0) ? 3'b010 : (m == 1) ? 3'b011 : (m == 2) ? 3'b110 : 3'b111;
      mode = 3'b000;
      writeVal(16'd30, 0);
      clearIrq();
      mode = code; subTick = 1;
      repeat (10) cyc();
      subTick = 0;
      chk("R12 frozen count", count, 30);
      chk("R12 no irq", irqFlag, 0);
    end
    mode = 3'b000;

    summary();
  end

endmodule